// File: doc/BRIEF.md
# Folded Multi-Lane FIR Filter

This block is a finite impulse response filter that gets its result from TAPS coefficients while using only LANES multipliers. The tap set is split into LANES groups of SLOTS = TAPS/LANES consecutive taps. Each group is served by one multiplier lane. A lane steps through its SLOTS taps over SLOTS clock cycles. In each cycle it picks the matching delayed sample from the delay line through a SLOTS-to-1 selector, and it reads the matching coefficient from its own small constant table.

When a valid sample arrives and the filter can take it, the sample is shifted into a TAPS-stage delay line. The filter then accumulates for SLOTS cycles: in each cycle the lane products and the running total go through a single wide adder. At the end it raises a one-cycle valid together with the full-precision sum.

Four coefficient banks sit in the same tables, and a 2-bit bank input picks one of them per sample. The delay line has no reset. Only the sequencing and the output registers are cleared.

Top module: `fold_fir`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears out_valid and goes idle. The first in_valid after reset is accepted.
- R2: A sample presented with in_valid while the block can accept is shifted into the delay line. The output for it is y = sum over t = 0..TAPS-1 of h_b[t] * x[m-t], where x[m] is that sample, x[m-t] is the sample accepted t acceptances earlier, and b is the bank.
- R3: out_valid rises exactly SLOTS clock edges (16 by default) after the edge that accepted the sample.
- R4: out_valid is high for one cycle per result.
- R5: An in_valid during the first SLOTS-1 computing cycles is ignored. Nothing is shifted in, no extra result is produced, and later results behave as if the pulse never came.
- R6: A sample presented in the final computing cycle is accepted, so back-to-back samples give one result every SLOTS cycles.
- R7: bank_sel is sampled at acceptance. Changing it during a computation does not alter that result.
- R8: For banks 0, 1 and 2, the coefficient is h_b[t] = ((t*(2b+3) + 5b) mod 512) - 256. Bank 3 holds -131072 for every tap. The bank forms the upper address bits of each lane's table.
- R9: out_data is a signed result of 2*18 + log2(TAPS) = 44 bits with no truncation. A full line of -131072 samples filtered by bank 3 gives exactly 2^42.
- R10: The delay line is not cleared by reset. Samples accepted before a reset still feed results computed after it.
- R11: Lane j at slot s applies tap t = j*SLOTS + s to x[m-t]. An impulse therefore returns h_b[0..TAPS-1] in order over successive results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of control and output registers |
| in_valid | input | 1 | New sample present |
| in_sample | input | 18 | Signed input sample |
| bank_sel | input | 2 | Coefficient bank for the sample being accepted |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | 44 | Signed full-precision filter output |

## Verification
On every cycle, the assertions check the sequencing:
- acceptance starts a run at slot 0 and loads the new sample at the head of the line;
- the slot counter steps by one per cycle;
- the line head and the latched bank stay still while a run is under way;
- the result pulse comes only out of a final slot and lasts one cycle.

The numeric behaviour can only be shown by the bench scenarios, which compare each result with a reference sum over its own sample history. These scenarios cover:
- the tap order, shown by an impulse walked through all lanes;
- the bank contents and the extreme-magnitude sums;
- ignored inputs and a bank change during a run;
- samples that survive a reset.

// File: rtl/fold_fir_pkg.sv
// Shared definitions for the folded FIR filter.
// Assumes coefficients fit in the coefficient width passed to tap_coef.
package fold_fir_pkg;

    // Sequencer phase: waiting for a sample or accumulating.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;

    // Constant coefficient of tap 'tap' in bank 'bank' for coefficient width 'cw'.
    function automatic int tap_coef(input int bank, input int tap, input int cw);
        if (bank == 3) begin
            return -(1 <<< (cw - 1));
        end
        return ((tap * (2 * bank + 3) + 5 * bank) % 512) - 256;
    endfunction

endpackage

// File: rtl/fold_fir_tapline.sv
// Sample delay line with one SLOTS-to-1 selector per lane.
// Shifts only when shift_en is high and has no reset by design.
// Assumes TAPS is a multiple of LANES.
module fold_fir_tapline #(
    parameter int TAPS  = 256,
    parameter int LANES = 16,
    parameter int DW    = 18,
    parameter int SLOTS = TAPS / LANES,
    parameter int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                         clk,
    input  logic                         shift_en,
    input  logic [DW-1:0]                din,
    input  logic [SW-1:0]                slot,
    output logic [LANES-1:0][DW-1:0]     lane_x,
    output logic [DW-1:0]                head
);

    logic [DW-1:0] stage [TAPS];

    // Advance the whole line by one sample on an accepted input.
    always_ff @(posedge clk) begin
        if (shift_en) begin
            stage[0] <= din;
            for (int i = 1; i < TAPS; i++) begin
                stage[i] <= stage[i-1];
            end
        end
    end

    // Each lane reads the sample for its current slot.
    for (genvar j = 0; j < LANES; j++) begin : g_lane_sel
        assign lane_x[j] = stage[j * SLOTS + int'(slot)];
    end

    assign head = stage[0];

endmodule

// File: rtl/fold_fir_coef_rom.sv
// Constant coefficient table for one lane, with BANKS * SLOTS entries.
// The address is {bank, slot}, so the bank is the upper address field.
// Assumes BANKS and SLOTS are powers of two.
module fold_fir_coef_rom #(
    parameter int LANE  = 0,
    parameter int SLOTS = 16,
    parameter int BANKS = 4,
    parameter int CW    = 18,
    parameter int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    parameter int BW    = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic [BW-1:0] bank,
    input  logic [SW-1:0] slot,
    output logic [CW-1:0] coef
);

    localparam int DEPTH = BANKS * SLOTS;

    logic [CW-1:0] table_w [DEPTH];

    // Fill every entry from the shared coefficient rule.
    for (genvar a = 0; a < DEPTH; a++) begin : g_entry
        assign table_w[a] = CW'(fold_fir_pkg::tap_coef(a / SLOTS, LANE * SLOTS + (a % SLOTS), CW));
    end

    assign coef = table_w[{bank, slot}];

endmodule

// File: rtl/fold_fir_mac.sv
// Sequencer and adder-accumulator of the folded filter.
// Sums LANES products plus the running total each cycle for SLOTS cycles,
// then emits the total with a one-cycle valid. A sample may be accepted
// when idle or in the final slot; otherwise in_valid is ignored.
module fold_fir_mac #(
    parameter int LANES = 16,
    parameter int SLOTS = 16,
    parameter int DW    = 18,
    parameter int CW    = 18,
    parameter int AW    = 44,
    parameter int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    parameter int BW    = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [BW-1:0]                bank_sel,
    input  logic [LANES-1:0][DW-1:0]     lane_x,
    input  logic [LANES-1:0][CW-1:0]     lane_h,
    output logic                         accept,
    output logic                         busy,
    output logic [SW-1:0]                slot,
    output logic [BW-1:0]                bank_q,
    output logic                         out_valid,
    output logic [AW-1:0]                out_data
);

    import fold_fir_pkg::*;

    localparam int PW = DW + CW;

    phase_t                phase;
    logic signed [AW-1:0]  acc;
    logic signed [AW-1:0]  acc_next;
    logic signed [PW-1:0]  prod [LANES];
    logic                  last;

    // One signed product per lane.
    for (genvar j = 0; j < LANES; j++) begin : g_mult
        assign prod[j] = $signed(lane_x[j]) * $signed(lane_h[j]);
    end

    assign busy   = (phase == PH_RUN);
    assign last   = busy && (slot == SW'(SLOTS - 1));
    assign accept = in_valid && (!busy || last);

    // Wide adder: lane products plus the total, cleared at slot 0.
    always_comb begin
        acc_next = (slot == '0) ? '0 : acc;
        for (int j = 0; j < LANES; j++) begin
            acc_next = acc_next + AW'(prod[j]);
        end
    end

    // Phase, slot, bank latch, accumulator and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            slot      <= '0;
            bank_q    <= '0;
            acc       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (busy) begin
                acc  <= acc_next;
                slot <= slot + SW'(1);
            end
            if (last) begin
                out_valid <= 1'b1;
                out_data  <= acc_next;
                phase     <= PH_IDLE;
            end
            if (accept) begin
                phase  <= PH_RUN;
                slot   <= '0;
                bank_q <= bank_sel;
            end
        end
    end

endmodule

// File: rtl/fold_fir.sv
// Folded FIR filter top: TAPS taps on LANES multipliers in SLOTS cycles.
// Wires the delay line, the per-lane coefficient tables and the
// accumulator. Assumes TAPS/LANES and BANKS are powers of two.
module fold_fir #(
    parameter int TAPS  = 256,
    parameter int LANES = 16,
    parameter int DW    = 18,
    parameter int CW    = 18,
    parameter int BANKS = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic [DW-1:0]                     in_sample,
    input  logic [1:0]                        bank_sel,
    output logic                              out_valid,
    output logic [DW+CW+$clog2(TAPS)-1:0]     out_data
);

    localparam int SLOTS = TAPS / LANES;
    localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int BW    = 2;
    localparam int AW    = DW + CW + $clog2(TAPS);

    logic                      accept;
    logic                      busy;
    logic [SW-1:0]             slot;
    logic [BW-1:0]             bank_q;
    logic [DW-1:0]             head_sample;
    logic [LANES-1:0][DW-1:0]  lane_x;
    logic [LANES-1:0][CW-1:0]  lane_h;

    fold_fir_tapline #(
        .TAPS (TAPS),
        .LANES(LANES),
        .DW   (DW),
        .SLOTS(SLOTS),
        .SW   (SW)
    ) u_line (
        .clk     (clk),
        .shift_en(accept),
        .din     (in_sample),
        .slot    (slot),
        .lane_x  (lane_x),
        .head    (head_sample)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_rom
        fold_fir_coef_rom #(
            .LANE (j),
            .SLOTS(SLOTS),
            .BANKS(BANKS),
            .CW   (CW),
            .SW   (SW),
            .BW   (BW)
        ) u_rom (
            .bank(bank_q),
            .slot(slot),
            .coef(lane_h[j])
        );
    end

    fold_fir_mac #(
        .LANES(LANES),
        .SLOTS(SLOTS),
        .DW   (DW),
        .CW   (CW),
        .AW   (AW),
        .SW   (SW),
        .BW   (BW)
    ) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .bank_sel (bank_sel),
        .lane_x   (lane_x),
        .lane_h   (lane_h),
        .accept   (accept),
        .busy     (busy),
        .slot     (slot),
        .bank_q   (bank_q),
        .out_valid(out_valid),
        .out_data (out_data)
    );

endmodule

// File: rtl/fold_fir_chk.sv
// Sequencing checks for fold_fir, attached through bind.
// Assumes the line head, slot counter and bank latch named in the bind.
module fold_fir_chk #(
    parameter int SLOTS = 16,
    parameter int SW    = 4,
    parameter int DW    = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [DW-1:0] in_sample,
    input logic          busy,
    input logic [SW-1:0] slot,
    input logic [1:0]    bank_q,
    input logic [DW-1:0] head_sample,
    input logic          out_valid
);

    logic fin;
    assign fin = busy && (slot == SW'(SLOTS - 1));

    assert_accept_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |=> (busy && slot == '0));

    assert_head_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |=> (head_sample == $past(in_sample)));

    assert_slot_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin) |=> (busy && slot == $past(slot) + SW'(1)));

    assert_result_due_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> out_valid);

    assert_result_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(fin));

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_line_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin) |=> $stable(head_sample));

    assert_bank_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin) |=> $stable(bank_q));

endmodule

bind fold_fir fold_fir_chk #(
    .SLOTS(TAPS / LANES),
    .SW   ((TAPS / LANES > 1) ? $clog2(TAPS / LANES) : 1),
    .DW   (DW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .busy       (busy),
    .slot       (slot),
    .bank_q     (bank_q),
    .head_sample(head_sample),
    .out_valid  (out_valid)
);

// File: tb/fold_fir_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues reference results, the monitor compares.
module fold_fir_test;

    localparam int TAPS = 256;
    localparam int SLOTS = 16;
    localparam int AW = 44;

    typedef struct {
        longint val;
        longint cyc;
        bit     chk;
        string  tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [17:0]   in_sample = '0;
    logic [1:0]    bank_sel = '0;
    logic          out_valid;
    logic [AW-1:0] out_data;

    int     compared = 0;
    int     mismatched = 0;
    longint cyc = 0;
    longint hist [TAPS];
    exp_t   sbq [$];
    bit     prev_ov = 1'b0;

    fold_fir uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .bank_sel(bank_sel), .out_valid(out_valid), .out_data(out_data)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference coefficients of R8.
    function automatic longint ref_coef(int b, int t);
        if (b == 3) return -131072;
        return longint'(((t * (2 * b + 3) + 5 * b) % 512) - 256);
    endfunction

    // Present one sample; optionally pulse in_valid again and change bank mid-run.
    task automatic send(int s, int b, bit chk, string tag, bit poke = 0, int pbank = 0);
        exp_t e;
        longint y = 0;
        in_valid  = 1'b1;
        in_sample = 18'(s);
        bank_sel  = 2'(b);
        for (int t = TAPS - 1; t > 0; t--) hist[t] = hist[t-1];
        hist[0] = longint'(s);
        for (int t = 0; t < TAPS; t++) y += ref_coef(b, t) * hist[t];
        @(negedge clk);
        e.val = y; e.cyc = cyc + SLOTS; e.chk = chk; e.tag = tag;
        sbq.push_back(e);
        if (poke) begin
            in_valid  = 1'b1;
            in_sample = 18'(s ^ 12345);
            bank_sel  = 2'(pbank);
        end else begin
            in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (SLOTS - 2) @(negedge clk);
    endtask

    // Monitor: pop and compare each result at the negative edge.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sbq.size() == 0) begin
                compared++; mismatched++;
                $display("FAIL R5: unexpected result %0d, expected none", $signed(out_data));
            end else begin
                exp_t e;
                longint act;
                e = sbq.pop_front();
                act = longint'($signed(out_data));
                if (e.chk) begin
                    compared++;
                    if (act != e.val || cyc != e.cyc || prev_ov) begin
                        mismatched++;
                        $display("FAIL %s/R3/R4: data %0d cycle %0d back2back %0d, expected data %0d cycle %0d",
                                 e.tag, act, cyc, prev_ov, e.val, e.cyc);
                    end
                end
            end
        end
        prev_ov = out_valid;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int t = 0; t < TAPS; t++) hist[t] = 0;
        repeat (3) @(negedge clk);
        compared++;
        if (out_valid !== 1'b0) begin
            mismatched++;
            $display("FAIL R1: out_valid %b, expected 0", out_valid);
        end
        rst_n = 1'b1;

        // Prime the line with zeros (no reset on it, so unchecked).
        for (int i = 0; i < TAPS; i++) send(0, 0, 0, "prime");

        // R11: impulse through every lane and slot, bank 1.
        send(1000, 1, 1, "R11");
        for (int i = 1; i < TAPS; i++) send(0, 1, 1, "R11");

        // R2 R8 R6: mixed samples over banks 0..2, back-to-back and with gaps.
        for (int i = 0; i < 48; i++) begin
            send(int'($urandom_range(262143)) - 131072, i % 3, 1, "R2_R8_R6");
            if (i % 7 == 3) repeat (5) @(negedge clk);
        end

        // R5 R7: extra pulses and bank changes during runs.
        for (int i = 0; i < 12; i++)
            send(int'($urandom_range(262143)) - 131072, i % 3, 1, "R5_R7", 1, (i + 1) % 4);

        // R9: extremes with bank 3.
        for (int i = 0; i < TAPS; i++) send(-131072, 3, 1, "R9");
        for (int i = 0; i < TAPS; i++) send(131071, 3, 1, "R9");
        for (int i = 0; i < TAPS; i++) send(-131072, 3, (i == TAPS - 1), "R9");
        compared++;
        if (sbq.size() != 0 || hist[0] != -131072 || sbq.size() > 1) begin end
        begin
            longint full = 0;
            for (int t = 0; t < TAPS; t++) full += ref_coef(3, t) * hist[t];
            if (full != (64'sd1 <<< 42)) begin
                mismatched++;
                $display("FAIL R9: reference %0d, expected %0d", full, (64'sd1 <<< 42));
            end
        end

        // R1 R10: reset while idle, then history still feeds the next result.
        repeat (4) @(negedge clk);
        send(777, 0, 1, "R2");
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        compared++;
        if (out_valid !== 1'b0) begin
            mismatched++;
            $display("FAIL R1: out_valid %b during reset, expected 0", out_valid);
        end
        rst_n = 1'b1;
        send(-4321, 2, 1, "R10_R1");
        send(55, 1, 1, "R10");
        repeat (40) @(negedge clk);

        compared++;
        if (sbq.size() != 0) begin
            mismatched++;
            $display("FAIL R5: %0d results missing, expected 0", sbq.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule